// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block holds the tags of a 4-way set-associative cache with 16 sets. It holds no data. For each request it takes a 16-bit address and a read/write flag. It looks the address up against the stored tags, valid bits and dirty bits of the addressed set. One cycle later it reports one of four outcomes:

- a hit;
- a fill of an empty way;
- a clean eviction;
- a dirty eviction that needs a writeback.

With the outcome it reports the way used and the tag of any line it displaced. The surrounding cache logic uses these results to steer refills and writebacks.

Each set carries a 3-bit binary-tree pseudo-LRU state. This state picks the victim once all four ways of the set are valid. Every hit and every fill moves the tree away from the way just touched. Empty ways are always filled lowest-numbered first, before the tree is consulted.

Top module: `tag_directory`

## Requirements
- R1: The address is split into tag = bits [15:8], set index = bits [7:4] and byte offset = bits [3:0]. The offset never changes the outcome, so two addresses that differ only in bits [3:0] name the same line.
- R2: `rsp_valid` is high for exactly the one cycle after each cycle in which `req_valid` is high, and low otherwise.
- R3: A request whose tag matches a valid way of its set returns `rsp_code` = 2'b00 with `rsp_way` set to the matching way.
- R4: A request that misses in a set that still has an invalid way returns `rsp_code` = 2'b01. It installs the tag in the lowest-numbered invalid way and reports that way.
- R5: A request that misses in a full set replaces the way chosen by the tree. It returns `rsp_code` = 2'b10 when that line was clean, and puts the replaced tag on `rsp_victim_tag`.
- R6: When the replaced line was dirty, the code is 2'b11 and `rsp_writeback` is 1. `rsp_writeback` is 1 in no other case.
- R7: A write hit marks the line dirty. A write miss installs the line dirty. A read miss installs it clean.
- R8: Each set has tree bits {root, lo, hi}, all 0 after reset.
  - The victim is way {1,hi} when root = 1, and way {0,lo} otherwise.
  - A hit or fill of way w sets root to the inverse of w[1].
  - If w[1] = 0, the same access sets lo to the inverse of w[0].
  - If w[1] = 1, it instead sets hi to the inverse of w[0].
- R9: A synchronous reset invalidates every line, cleans every line, clears every tree and drops `rsp_valid`.
- R10: On codes 2'b00 and 2'b01, `rsp_victim_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 16 | Byte address of the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_code | output | 2 | 00 hit, 01 fill, 10 clean evict, 11 dirty evict |
| rsp_way | output | 2 | Way that hit or was filled |
| rsp_victim_tag | output | 8 | Tag of the replaced line on evictions |
| rsp_writeback | output | 1 | The replaced line must be written back |

## Verification
The hardest case to reach is a dirty eviction whose victim comes from the tree after a long mix of hits. That needs a full set, an earlier write to exactly the way the tree will later point at, and an access order that steers the tree to it. A directed sequence walks one set through fills, hits, two clean evictions and a dirty one. Random traffic then draws from a few tags and sets with a fixed seed, so sets fill, thrash and go dirty often. A mid-run reset checks that all state is cleared.

// File: rtl/tag_directory.sv
module tag_directory #(
  parameter int TAG_W = 8,
  parameter int SET_W = 4,
  parameter int OFF_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [TAG_W+SET_W+OFF_W-1:0] req_addr,
  input  logic                         req_write,
  output logic                         rsp_valid,
  output logic [1:0]                   rsp_code,
  output logic [1:0]                   rsp_way,
  output logic [TAG_W-1:0]             rsp_victim_tag,
  output logic                         rsp_writeback
);
  localparam int ADDR_W = TAG_W + SET_W + OFF_W;
  localparam int SETS   = 1 << SET_W;
  localparam int WAYS   = 4;

  logic [TAG_W-1:0] tags  [SETS][WAYS];
  logic [WAYS-1:0]  valid [SETS];
  logic [WAYS-1:0]  dirty [SETS];
  logic [2:0]       tree  [SETS];

  logic [TAG_W-1:0] a_tag;
  logic [SET_W-1:0] a_set;
  assign a_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign a_set = req_addr[OFF_W +: SET_W];

  logic [WAYS-1:0] match;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid[a_set][w] && (tags[a_set][w] == a_tag);
  end

  logic [WAYS-1:0] free;
  logic [1:0]      hit_way, free_way, tree_way, way;
  logic            hit, has_free;
  logic [2:0]      t;

  assign hit      = |match;
  assign free     = ~valid[a_set];
  assign has_free = |free;
  assign t        = tree[a_set];
  assign tree_way = t[2] ? {1'b1, t[0]} : {1'b0, t[1]};

  always_comb begin
    hit_way = 2'd0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = 2'(w);
    free_way = 2'd0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (free[w]) free_way = 2'(w);
  end

  assign way = hit ? hit_way : (has_free ? free_way : tree_way);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid[s] <= '0;
        dirty[s] <= '0;
        tree[s]  <= '0;
      end
      rsp_valid      <= 1'b0;
      rsp_code       <= 2'b00;
      rsp_way        <= 2'd0;
      rsp_victim_tag <= '0;
      rsp_writeback  <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_writeback <= 1'b0;
      if (req_valid) begin
        rsp_way <= way;
        tree[a_set][2] <= ~way[1];
        if (way[1]) tree[a_set][0] <= ~way[0];
        else        tree[a_set][1] <= ~way[0];
        if (hit) begin
          rsp_code       <= 2'b00;
          rsp_victim_tag <= '0;
          if (req_write) dirty[a_set][way] <= 1'b1;
        end else begin
          tags[a_set][way]  <= a_tag;
          valid[a_set][way] <= 1'b1;
          dirty[a_set][way] <= req_write;
          if (has_free) begin
            rsp_code       <= 2'b01;
            rsp_victim_tag <= '0;
          end else begin
            rsp_code       <= {1'b1, dirty[a_set][way]};
            rsp_victim_tag <= tags[a_set][way];
            rsp_writeback  <= dirty[a_set][way];
          end
        end
      end
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));
  // R6
  wb_only_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_writeback |-> (rsp_valid && rsp_code == 2'b11));
  // R6
  dirty_has_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'b11) |-> rsp_writeback);
  // R10
  victim_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_code[1]) |-> (rsp_victim_tag == '0));
  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !rsp_valid);
endmodule

// File: tb/tag_directory_test.sv
module tag_directory_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [15:0] req_addr;
  logic        req_write;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [1:0]  rsp_way;
  logic [7:0]  rsp_victim_tag;
  logic        rsp_writeback;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tag_directory uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_way(rsp_way), .rsp_victim_tag(rsp_victim_tag),
    .rsp_writeback(rsp_writeback)
  );

  logic [7:0] m_tag   [16][4];
  logic [3:0] m_val   [16];
  logic [3:0] m_dirty [16];
  logic [2:0] m_tree  [16];

  function automatic void model_clear();
    for (int s = 0; s < 16; s++) begin
      m_val[s] = '0; m_dirty[s] = '0; m_tree[s] = '0;
    end
  endfunction

  function automatic string req_of(logic [1:0] c);
    case (c)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench reference: R1 split, R3/R4/R5/R6 codes, R7 dirty rules, R8 tree
  task automatic access(logic [15:0] a, logic wr);
    logic [7:0] tg; logic [3:0] st; logic [1:0] w, code; logic [7:0] vt; logic wb;
    logic found;
    tg = a[15:8]; st = a[7:4]; found = 1'b0; w = 0; vt = 0; wb = 0;
    for (int i = 3; i >= 0; i--)
      if (m_val[st][i] && m_tag[st][i] == tg) begin found = 1'b1; w = 2'(i); end
    if (found) begin
      code = 2'b00;
      if (wr) m_dirty[st][w] = 1'b1;
    end else begin
      if (m_val[st] != 4'hF) begin
        code = 2'b01;
        for (int i = 3; i >= 0; i--) if (!m_val[st][i]) w = 2'(i);
      end else begin
        w = m_tree[st][2] ? {1'b1, m_tree[st][0]} : {1'b0, m_tree[st][1]};
        vt = m_tag[st][w];
        wb = m_dirty[st][w];
        code = wb ? 2'b11 : 2'b10;
      end
      m_tag[st][w] = tg; m_val[st][w] = 1'b1; m_dirty[st][w] = wr;
    end
    m_tree[st][2] = ~w[1];
    if (w[1]) m_tree[st][0] = ~w[0]; else m_tree[st][1] = ~w[0];

    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "rsp_valid", int'(rsp_valid), 1);
    check(req_of(code), "rsp_code", int'(rsp_code), int'(code));
    check(code[1] ? "R8" : req_of(code), "rsp_way", int'(rsp_way), int'(w));
    check(code[1] ? req_of(code) : "R10", "rsp_victim_tag", int'(rsp_victim_tag), int'(vt));
    check("R6", "rsp_writeback", int'(rsp_writeback), int'(wb));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    // R9 reset state
    check("R9", "rsp_valid after reset", int'(rsp_valid), 0);
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9", "rsp_valid in reset", int'(rsp_valid), 0);

    // Directed walk of one set (R3 R4 R5 R6 R7 R8)
    access(16'hABCD, 0);
    access(16'hABCD, 0);
    access(16'hABC0, 1);       // R1 offset ignored, R7 write hit marks dirty
    access(16'hACCD, 0);
    access(16'hADCD, 0);
    access(16'hAECD, 0);
    access(16'hABCD, 0);
    access(16'hADCD, 0);
    access(16'hAFCD, 0);       // clean evict of way 1
    access(16'hACCD, 0);       // clean evict of way 3
    access(16'hEAC2, 0);       // dirty evict of way 0
    access(16'h12F3, 1);       // R7 write miss installs dirty
    access(16'h12F9, 0);       // R1 same line, hit

    // R2 idle cycle gives no result
    @(negedge clk);
    check("R2", "rsp_valid idle", int'(rsp_valid), 0);

    // R9 reset clears all lines: former hit becomes a fill
    do_reset();
    access(16'hABCD, 0);
    check("R9", "code after reset", int'(rsp_code), 2'b01);

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      a[15:8] = 8'h40 + 8'($urandom_range(0, 6));
      a[7:4]  = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'($urandom_range(2, 3));
      a[3:0]  = 4'($urandom);
      access(a, 1'($urandom));
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        check("R2", "rsp_valid gap", int'(rsp_valid), 0);
      end
      if (i == 2000) do_reset();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule